// File: doc/BRIEF.md
# LIN Controller Interrupt Flag Unit

This block keeps the interrupt bookkeeping of a LIN/UART communication controller. The protocol engine sends one-cycle event pulses: one for each detailed error cause, one for identifier handling, one for a finished transmit response and one for a finished receive response. Each pulse sets a sticky status flag. Every error cause also latches its own bit in a detailed error vector. A four-bit enable mask decides which flags drive the single interrupt request line.

Software reaches the block through a byte-wide register port. The port has a two-bit address, read and write strobes and combinational read data. Software clears a flag by writing a one to its bit. When the mode input selects UART operation, touching the data register also clears flags as a side effect: a read releases the error and receive flags, and a write releases the transmit flag. The data path itself lives elsewhere, so in this block a data-register read returns zero.

The identifier flag covers both controller roles. A slave task raises it when an identifier has been received. A master task raises it when it has finished sending the header.

Top module: `lin_irq_unit`

## Requirements
- R1: After reset, the status, enable and detailed error registers all read zero and `irq` is low. The address map is: 0 status, 1 enable, 2 detailed error vector, 3 data register. A read of the data register returns zero.
- R2: Status bit 3 is the error flag, bit 2 the identifier flag, bit 1 the transmit-complete flag and bit 0 the receive-complete flag. Bits 7:4 read zero. Writing a 1 to one of bits 3:0 clears that flag. Writing a 0 leaves the flag unchanged.
- R3: Clearing the error flag, by any means, clears every bit of the detailed error vector.
- R4: With `uart_mode` high, a read of the data register clears the error flag and the receive-complete flag. It leaves the identifier flag and the transmit-complete flag unchanged.
- R5: With `uart_mode` high, a write of the data register clears the transmit-complete flag only.
- R6: With `uart_mode` low, a read or a write of the data register leaves all flags and the error vector unchanged.
- R7: When a set event and a clear hit the same flag in the same cycle, the flag ends up set. If the error flag is cleared in the same cycle as new error pulses arrive, the error vector then holds exactly those new pulses.
- R8: The enable register is read/write in bits 3:0. Bits 7:4 always read zero and ignore writes.
- R9: `irq` is high exactly when at least one status flag is set together with its enable bit. Enable bit 3 gates the error flag, bit 2 the identifier flag, bit 1 transmit and bit 0 receive.
- R10: Each bit of `err_ev` sets its own bit of the detailed error vector, and that bit stays set until the error flag is cleared. Any nonzero `err_ev` sets the error flag.
- R11: A pulse on `id_ev`, `tx_ev` or `rx_ev` sets the identifier, transmit-complete or receive-complete flag on the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| uart_mode | input | 1 | High selects UART mode (enables data-register side-effect clears) |
| reg_addr | input | 2 | Register address |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Combinational read data |
| err_ev | input | ERR_W | Detailed error-cause pulses |
| id_ev | input | 1 | Identifier received / header sent pulse |
| tx_ev | input | 1 | Transmit response complete pulse |
| rx_ev | input | 1 | Receive response complete pulse |
| irq | output | 1 | Interrupt request |

## Verification
The collision that matters is a hardware set event and a software clear landing on the same flag in the same cycle. The clear can come from a write-one to the status register, or from the implicit clear of a UART data access. The stimulus table drives an event pulse on the same clock edge as a status write that names the same bit. It does the same with a fresh error pulse during an error-flag clear. It then reads the status register and the detailed error vector back through the register port. The test is judged correct when the flag is still set and the vector holds only the newly arrived error causes.

// File: rtl/lin_irq_pkg.sv
package lin_irq_pkg;

    typedef enum logic [1:0] {
        RA_STATUS = 2'd0,
        RA_ENABLE = 2'd1,
        RA_ERRVEC = 2'd2,
        RA_DATA   = 2'd3
    } reg_addr_e;

    // Packed order fixes the status bit positions: err=3, id=2, tx=1, rx=0.
    typedef struct packed {
        logic err;
        logic id;
        logic tx;
        logic rx;
    } irq_src_t;

    localparam int NUM_SRC = 4;

    function automatic logic [7:0] widen4(input irq_src_t s);
        return {4'b0000, s};
    endfunction

endpackage

// File: rtl/lin_irq_flags.sv
module lin_irq_flags
    import lin_irq_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  irq_src_t set_i,
    input  irq_src_t clr_i,
    output irq_src_t flags_o
);
    localparam int N = NUM_SRC;

    logic [N-1:0] q;
    logic [N-1:0] set_v;
    logic [N-1:0] clr_v;

    assign set_v   = set_i;
    assign clr_v   = clr_i;
    assign flags_o = irq_src_t'(q);

    for (genvar i = 0; i < N; i++) begin : g_flag
        always_ff @(posedge clk) begin
            if (rst)
                q[i] <= 1'b0;
            else if (set_v[i])
                q[i] <= 1'b1;
            else if (clr_v[i])
                q[i] <= 1'b0;
        end

        // R7
        set_wins_chk: assert property (@(posedge clk) disable iff (rst)
            set_v[i] |=> q[i]);

        // R2
        clear_takes_chk: assert property (@(posedge clk) disable iff (rst)
            (clr_v[i] && !set_v[i]) |=> !q[i]);

        // R6
        flag_hold_chk: assert property (@(posedge clk) disable iff (rst)
            (!clr_v[i] && !set_v[i]) |=> (q[i] == $past(q[i])));
    end
endmodule

// File: rtl/lin_irq_errvec.sv
module lin_irq_errvec #(
    parameter int ERR_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wipe_i,
    input  logic [ERR_W-1:0] ev_i,
    output logic [ERR_W-1:0] vec_o
);
    logic [ERR_W-1:0] vec_q;
    logic [ERR_W-1:0] base;

    assign base  = wipe_i ? '0 : vec_q;
    assign vec_o = vec_q;

    always_ff @(posedge clk) begin
        if (rst)
            vec_q <= '0;
        else
            vec_q <= base | ev_i;
    end

    // R3
    wipe_chk: assert property (@(posedge clk) disable iff (rst)
        wipe_i |=> (vec_q == $past(ev_i)));

    // R10
    sticky_chk: assert property (@(posedge clk) disable iff (rst)
        !wipe_i |=> ((vec_q & $past(vec_q)) == $past(vec_q)));
endmodule

// File: rtl/lin_irq_enable.sv
module lin_irq_enable
    import lin_irq_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     wr_i,
    input  irq_src_t wdata_i,
    output irq_src_t en_o
);
    irq_src_t en_q;

    always_ff @(posedge clk) begin
        if (rst)
            en_q <= '0;
        else if (wr_i)
            en_q <= wdata_i;
    end

    assign en_o = en_q;

    // R8
    en_write_chk: assert property (@(posedge clk) disable iff (rst)
        wr_i |=> (en_q == $past(wdata_i)));

    // R8
    en_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !wr_i |=> $stable(en_q));
endmodule

// File: rtl/lin_irq_unit.sv
module lin_irq_unit
    import lin_irq_pkg::*;
#(
    parameter int ERR_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             uart_mode,
    input  logic [1:0]       reg_addr,
    input  logic             reg_wr,
    input  logic             reg_rd,
    input  logic [7:0]       reg_wdata,
    output logic [7:0]       reg_rdata,
    input  logic [ERR_W-1:0] err_ev,
    input  logic             id_ev,
    input  logic             tx_ev,
    input  logic             rx_ev,
    output logic             irq
);
    localparam int VEC_PAD = 8 - ERR_W;

    reg_addr_e addr;
    irq_src_t  set_s, clr_s, w1c_s, uart_s, flags, en;
    logic      st_wr, en_wr, data_rd, data_wr;
    logic [ERR_W-1:0] errvec;
    logic [3:0] unused_wdata_hi;

    assign addr            = reg_addr_e'(reg_addr);
    assign unused_wdata_hi = reg_wdata[7:4];

    assign st_wr   = reg_wr && (addr == RA_STATUS);
    assign en_wr   = reg_wr && (addr == RA_ENABLE);
    assign data_rd = reg_rd && (addr == RA_DATA) && uart_mode;
    assign data_wr = reg_wr && (addr == RA_DATA) && uart_mode;

    always_comb begin
        set_s     = '0;
        set_s.err = |err_ev;
        set_s.id  = id_ev;
        set_s.tx  = tx_ev;
        set_s.rx  = rx_ev;

        w1c_s = st_wr ? irq_src_t'(reg_wdata[3:0]) : '0;

        uart_s     = '0;
        uart_s.err = data_rd;
        uart_s.rx  = data_rd;
        uart_s.tx  = data_wr;

        clr_s = w1c_s | uart_s;
    end

    lin_irq_flags u_flags (
        .clk     (clk),
        .rst     (rst),
        .set_i   (set_s),
        .clr_i   (clr_s),
        .flags_o (flags)
    );

    lin_irq_errvec #(.ERR_W(ERR_W)) u_errvec (
        .clk    (clk),
        .rst    (rst),
        .wipe_i (clr_s.err),
        .ev_i   (err_ev),
        .vec_o  (errvec)
    );

    lin_irq_enable u_enable (
        .clk     (clk),
        .rst     (rst),
        .wr_i    (en_wr),
        .wdata_i (irq_src_t'(reg_wdata[3:0])),
        .en_o    (en)
    );

    assign irq = |(flags & en);

    always_comb begin
        unique case (addr)
            RA_STATUS: reg_rdata = widen4(flags);
            RA_ENABLE: reg_rdata = widen4(en);
            RA_ERRVEC: begin
                if (VEC_PAD > 0)
                    reg_rdata = {{VEC_PAD{1'b0}}, errvec};
                else
                    reg_rdata = errvec[7:0];
            end
            default:   reg_rdata = 8'h00;
        endcase
    end

    // R9
    irq_masked_chk: assert property (@(posedge clk) disable iff (rst)
        (en == '0) |-> !irq);

    // R9
    irq_src_chk: assert property (@(posedge clk) disable iff (rst)
        irq |-> (flags != '0));

    // R6
    lin_data_inert_chk: assert property (@(posedge clk) disable iff (rst)
        (!uart_mode && (reg_rd || reg_wr) && addr == RA_DATA
         && set_s == '0) |=> (flags == $past(flags)));

    // R4
    uart_rd_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (uart_mode && reg_rd && addr == RA_DATA && err_ev == '0 && !rx_ev)
        |=> (!flags.err && !flags.rx && errvec == '0));

    // R5
    uart_wr_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (uart_mode && reg_wr && addr == RA_DATA && !tx_ev) |=> !flags.tx);
endmodule

// File: tb/tb_lin_irq_unit.sv
module tb_lin_irq_unit;
    localparam int ERR_W = 8;
    localparam int NROW  = 15;

    logic clk = 1'b0;
    logic rst;
    logic uart_mode;
    logic [1:0] reg_addr;
    logic reg_wr, reg_rd;
    logic [7:0] reg_wdata, reg_rdata;
    logic [ERR_W-1:0] err_ev;
    logic id_ev, tx_ev, rx_ev, irq;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    lin_irq_unit #(.ERR_W(ERR_W)) dut (
        .clk(clk), .rst(rst), .uart_mode(uart_mode), .reg_addr(reg_addr),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .err_ev(err_ev), .id_ev(id_ev),
        .tx_ev(tx_ev), .rx_ev(rx_ev), .irq(irq)
    );

    // Row layout: [36] uart [35] wr [34] rd [33:32] addr [31:24] wdata
    // [23:16] err_ev [15:13] {id,tx,rx} [12:9] status [8:1] errvec [0] irq
    // The enable register holds 4'hF while the table runs.
    localparam logic [36:0] VEC [NROW] = '{
        {3'b000, 2'd0, 8'h00, 8'h00, 3'b001, 4'b0001, 8'h00, 1'b1}, // R11 rx
        {3'b000, 2'd0, 8'h00, 8'h00, 3'b010, 4'b0011, 8'h00, 1'b1}, // R11 tx
        {3'b000, 2'd0, 8'h00, 8'h00, 3'b100, 4'b0111, 8'h00, 1'b1}, // R11 id
        {3'b000, 2'd0, 8'h00, 8'h05, 3'b000, 4'b1111, 8'h05, 1'b1}, // R10
        {3'b000, 2'd0, 8'h00, 8'h10, 3'b000, 4'b1111, 8'h15, 1'b1}, // R10 sticky
        {3'b010, 2'd0, 8'h00, 8'h00, 3'b000, 4'b1111, 8'h15, 1'b1}, // R2 zeros
        {3'b010, 2'd0, 8'h02, 8'h00, 3'b000, 4'b1101, 8'h15, 1'b1}, // R2 w1c
        {3'b001, 2'd3, 8'h00, 8'h00, 3'b000, 4'b1101, 8'h15, 1'b1}, // R6 rd
        {3'b101, 2'd3, 8'h00, 8'h00, 3'b000, 4'b0100, 8'h00, 1'b1}, // R4 R3
        {3'b000, 2'd0, 8'h00, 8'h00, 3'b011, 4'b0111, 8'h00, 1'b1}, // R11
        {3'b110, 2'd3, 8'hAA, 8'h00, 3'b000, 4'b0101, 8'h00, 1'b1}, // R5
        {3'b010, 2'd3, 8'hFF, 8'h00, 3'b000, 4'b0101, 8'h00, 1'b1}, // R6 wr
        {3'b010, 2'd0, 8'h01, 8'h00, 3'b001, 4'b0101, 8'h00, 1'b1}, // R7
        {3'b010, 2'd0, 8'h0F, 8'h02, 3'b000, 4'b1000, 8'h02, 1'b1}, // R7 R3
        {3'b010, 2'd0, 8'h08, 8'h00, 3'b000, 4'b0000, 8'h00, 1'b0}  // R3 R9
    };

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle();
        reg_wr = 1'b0; reg_rd = 1'b0; reg_addr = 2'd0; reg_wdata = 8'h00;
        err_ev = '0; id_ev = 1'b0; tx_ev = 1'b0; rx_ev = 1'b0;
    endtask

    function automatic logic [7:0] peek(input logic [1:0] a);
        reg_addr = a;
        return 8'h00;
    endfunction

    task automatic rd_reg(input logic [1:0] a, output logic [7:0] d);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic wr_reg(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        idle();
    endtask

    task automatic pulse_id();
        @(negedge clk);
        id_ev = 1'b1;
        @(negedge clk);
        idle();
    endtask

    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog: run did not complete");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] d;
        logic [7:0] dummy;
        rst = 1'b1; uart_mode = 1'b0;
        idle();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        rd_reg(2'd0, d); chk("R1 status", d, 8'h00);
        rd_reg(2'd1, d); chk("R1 enable", d, 8'h00);
        rd_reg(2'd2, d); chk("R1 errvec", d, 8'h00);
        rd_reg(2'd3, d); chk("R1 data", d, 8'h00);
        chk("R1 irq", {7'd0, irq}, 8'h00);

        // R8 reserved enable bits
        wr_reg(2'd1, 8'hFF);
        rd_reg(2'd1, d); chk("R8 enable", d, 8'h0F);

        for (int r = 0; r < NROW; r++) begin
            @(negedge clk);
            uart_mode = VEC[r][36];
            reg_wr    = VEC[r][35];
            reg_rd    = VEC[r][34];
            reg_addr  = VEC[r][33:32];
            reg_wdata = VEC[r][31:24];
            err_ev    = VEC[r][23:16];
            {id_ev, tx_ev, rx_ev} = VEC[r][15:13];
            @(negedge clk);
            idle();
            rd_reg(2'd0, d);
            chk($sformatf("R2 R7 status row %0d", r), d, {4'd0, VEC[r][12:9]});
            rd_reg(2'd2, d);
            chk($sformatf("R3 R10 errvec row %0d", r), d, VEC[r][8:1]);
            chk($sformatf("R9 irq row %0d", r), {7'd0, irq}, {7'd0, VEC[r][0]});
        end
        uart_mode = 1'b0;

        // R9 masking: only the identifier flag set
        pulse_id();
        wr_reg(2'd1, 8'h01);
        #1 chk("R9 masked id", {7'd0, irq}, 8'h00);
        wr_reg(2'd1, 8'h04);
        #1 chk("R9 enabled id", {7'd0, irq}, 8'h01);
        wr_reg(2'd1, 8'h30);
        rd_reg(2'd1, d); chk("R8 upper ignored", d, 8'h00);
        #1 chk("R9 all masked", {7'd0, irq}, 8'h00);

        // R1 synchronous reset clears flags and enables
        wr_reg(2'd1, 8'h0F);
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        rd_reg(2'd0, d); chk("R1 status after reset", d, 8'h00);
        rd_reg(2'd1, d); chk("R1 enable after reset", d, 8'h00);
        dummy = peek(2'd0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule